// File: doc/BRIEF.md
# Regulator Enable and Supervision Controller

This block decides the operating state of a switching regulator from a handful of digital inputs. The inputs are the external enable pin, the converter-enable control bit, and comparator outputs for input undervoltage, input overvoltage, over-temperature (hot and cooled thresholds) and the output-voltage window (above 95 % and below 90 % of nominal). The block resolves these into one of three device states: off with output discharge, interface-only with a high-impedance output, or running. In the running state it gates the power-stage switching. It waits a fixed start-up delay after entering the running state, and it pauses switching on its own during input overvoltage or thermal faults.

It also produces a power-good flag. The flag sets with hysteresis as soon as the output is above the upper comparator. It clears only after the lower comparator has been asserted for a programmable run of consecutive cycles. A one-cycle pulse marks each new thermal event for the status flag kept elsewhere. Forced-PWM permission is withheld until power-good has been seen once in the current running episode. All comparator and pin inputs cross into the clock domain through a synchroniser of `SYNC_STAGES` flops. The delays are cycle counts (`START_DLY`, `PG_FALL_DLY`) that the integrator sets from the clock rate.

Top module: `pwr_supervisor`

## Requirements
- R1: When the synchronised enable pin is low or the synchronised undervoltage comparator is high, `dev_state` is 2'b00 and `discharge_on` is 1, whatever `ctl_enable` holds; `sw_en` is 0.
- R2: With the pin high, no undervoltage and `ctl_enable` = 0, `dev_state` is 2'b01, `out_hiz` is 1 and `sw_en` is 0.
- R3: With the pin high, no undervoltage and `ctl_enable` = 1, `dev_state` is 2'b10 and both `discharge_on` and `out_hiz` are 0.
- R4: Each pin and comparator input passes through two flops before it is used, so a pin change shows on `dev_state` on the third rising edge after it is applied; `ctl_enable` acts on the next edge.
- R5: `ramp_start` rises `START_DLY` (default 40) edges after `dev_state` becomes 2'b10. It clears on leaving 2'b10. `sw_en` is never 1 before `ramp_start`.
- R6: While the synchronised overvoltage comparator is high, `sw_en` is 0; it returns without any other action once the comparator falls.
- R7: A synchronised hot comparator forces `sw_en` to 0 and gives a one-cycle `tset_pulse` on entry into the fault. The fault stays latched until the cooled comparator is seen while hot is low.
- R8: `pgood` sets on the edge after the synchronised upper comparator is seen in the running state. It clears only after `PG_FALL_DLY` (default 16) consecutive cycles of the synchronised lower comparator. Any cycle without the lower comparator restarts that count.
- R9: One edge after `dev_state` leaves 2'b10, `pgood` is 0, and it stays 0 outside the running state.
- R10: `fpwm_ok` equals `ctl_fpwm` ANDed with a latch that sets once `pgood` has been 1 during the current running episode. The latch clears one edge after the running state is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | External device enable pin |
| uvlo_cmp | input | 1 | Input undervoltage comparator, 1 = too low |
| vin_ov_cmp | input | 1 | Input overvoltage comparator, 1 = too high |
| hot_cmp | input | 1 | Temperature above the rising fault threshold |
| cool_cmp | input | 1 | Temperature below the falling restart threshold |
| vout_hi_cmp | input | 1 | Output above 95 % of nominal |
| vout_lo_cmp | input | 1 | Output below 90 % of nominal |
| ctl_enable | input | 1 | Converter-enable control bit |
| ctl_fpwm | input | 1 | Forced-PWM request bit |
| dev_state | output | 2 | 00 off, 01 interface-only, 10 running |
| discharge_on | output | 1 | Output discharge path active |
| out_hiz | output | 1 | Output held high-impedance |
| sw_en | output | 1 | Power-stage switching allowed |
| ramp_start | output | 1 | Start-up delay elapsed, output ramp may begin |
| pgood | output | 1 | Power-good with hysteresis and falling filter |
| fpwm_ok | output | 1 | Forced-PWM permitted |
| tset_pulse | output | 1 | One-cycle pulse that sets the thermal flag |

## Verification
Two cases can land on the same edge. In the first, the power-good falling filter reaches its count on the very edge where the running state is left. In the second, a thermal fault begins while an input overvoltage already holds switching off. The bench builds both on purpose. It lines up `ctl_enable` clearing with the last cycle of the lower-comparator run, and it raises hot during an overvoltage burst. A behavioural model then judges each edge: `pgood` must fall exactly once and `pg_seen`-driven `fpwm_ok` must clear, and `tset_pulse` must still appear once, with `sw_en` held low until both conditions have gone. Randomised stretches then mix all inputs so such overlaps also occur unplanned.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'b00,
    PS_IFACE = 2'b01,
    PS_RUN   = 2'b10
  } pstate_e;

  // Enable truth table with undervoltage folded into the off state.
  function automatic pstate_e resolve_state(input logic pin_en,
                                            input logic uvlo,
                                            input logic ctl_en);
    if (!pin_en || uvlo) return PS_OFF;
    if (!ctl_en)         return PS_IFACE;
    return PS_RUN;
  endfunction

  // True on the last cycle of a run of lim cycles counted from zero.
  function automatic logic last_tick(input int unsigned cnt,
                                     input int unsigned lim);
    return cnt == (lim - 1);
  endfunction

  // Next value of a set/clear latch with set priority.
  function automatic logic sr_next(input logic cur,
                                   input logic set_c,
                                   input logic clr_c);
    if (set_c) return 1'b1;
    if (clr_c) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[gi] <= '0;
        else        pipe[gi] <= pipe[gi-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/pwr_start_timer.sv
module pwr_start_timer #(
  parameter int DLY = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  import pwr_sup_pkg::*;

  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = last_tick(32'(cnt), DLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (hit) done <= 1'b1;
      else     cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwr_pg_filter.sv
module pwr_pg_filter #(
  parameter int FALL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic above_hi,
  input  logic below_lo,
  output logic pg,
  output logic fall_expire
);
  import pwr_sup_pkg::*;

  localparam int CW = (FALL < 2) ? 1 : $clog2(FALL);

  logic [CW-1:0] cnt;

  assign fall_expire = run && pg && below_lo && last_tick(32'(cnt), FALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg  <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      pg  <= 1'b0;
      cnt <= '0;
    end else if (!pg) begin
      cnt <= '0;
      if (above_hi) pg <= 1'b1;
    end else if (below_lo) begin
      if (fall_expire) begin
        pg  <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

endmodule

// File: rtl/pwr_thermal.sv
module pwr_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic cool,
  output logic off,
  output logic set_pulse
);
  import pwr_sup_pkg::*;

  logic entry;

  assign entry = hot && !off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off       <= 1'b0;
      set_pulse <= 1'b0;
    end else begin
      off       <= sr_next(off, hot, cool);
      set_pulse <= entry;
    end
  end

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int START_DLY   = 40,
  parameter int PG_FALL_DLY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       uvlo_cmp,
  input  logic       vin_ov_cmp,
  input  logic       hot_cmp,
  input  logic       cool_cmp,
  input  logic       vout_hi_cmp,
  input  logic       vout_lo_cmp,
  input  logic       ctl_enable,
  input  logic       ctl_fpwm,
  output logic [1:0] dev_state,
  output logic       discharge_on,
  output logic       out_hiz,
  output logic       sw_en,
  output logic       ramp_start,
  output logic       pgood,
  output logic       fpwm_ok,
  output logic       tset_pulse
);
  import pwr_sup_pkg::*;

  localparam int NSYNC = 7;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic en_s, uv_s, ov_s, hot_s, cool_s, hi_s, lo_s;
  pstate_e state_q;
  logic run, start_done, thermal_off, pg_q, pg_expire, pg_seen;

  assign raw_in = {en_pin, uvlo_cmp, vin_ov_cmp, hot_cmp,
                   cool_cmp, vout_hi_cmp, vout_lo_cmp};

  pwr_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {en_s, uv_s, ov_s, hot_s, cool_s, hi_s, lo_s} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_OFF;
    else        state_q <= resolve_state(en_s, uv_s, ctl_enable);
  end

  assign run = (state_q == PS_RUN);

  pwr_start_timer #(.DLY(START_DLY)) u_start (
    .clk(clk), .rst_n(rst_n), .run(run), .done(start_done)
  );

  pwr_thermal u_therm (
    .clk(clk), .rst_n(rst_n), .hot(hot_s), .cool(cool_s),
    .off(thermal_off), .set_pulse(tset_pulse)
  );

  pwr_pg_filter #(.FALL(PG_FALL_DLY)) u_pg (
    .clk(clk), .rst_n(rst_n), .run(run), .above_hi(hi_s),
    .below_lo(lo_s), .pg(pg_q), .fall_expire(pg_expire)
  );

  // First power-good latch, restarted on every exit from the running state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pg_seen <= 1'b0;
    else if (!run) pg_seen <= 1'b0;
    else if (pg_q) pg_seen <= 1'b1;
  end

  assign dev_state    = state_q;
  assign discharge_on = (state_q == PS_OFF);
  assign out_hiz      = (state_q == PS_IFACE);
  assign ramp_start   = start_done;
  assign sw_en        = run && start_done && !ov_s && !thermal_off;
  assign pgood        = pg_q;
  assign fpwm_ok      = ctl_fpwm && pg_seen;

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state_q,
  input logic       discharge_on,
  input logic       out_hiz,
  input logic       sw_en,
  input logic       ramp_start,
  input logic       pgood,
  input logic       fpwm_ok,
  input logic       tset_pulse,
  input logic       ov_s,
  input logic       thermal_off,
  input logic       hi_s,
  input logic       lo_s,
  input logic       pg_seen,
  input logic       pg_expire
);

  a_r1_off_discharge: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 2'b00) |-> (discharge_on && !sw_en));

  a_r2_iface_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> ((state_q == 2'b01) && !sw_en && !discharge_on));

  a_r5_no_early_switch: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> ramp_start);

  a_r6_ov_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |-> !sw_en);

  a_r7_hot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_off |-> !sw_en);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tset_pulse |=> !tset_pulse);

  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(hi_s));

  a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pgood) && ($past(state_q) == 2'b10)) |-> $past(pg_expire && lo_s));

  a_r9_pg_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != 2'b10) |=> !pgood);

  a_r10_seen_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_seen) |-> $past(pgood));

  a_r10_fpwm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != 2'b10) |=> !fpwm_ok);

endmodule

bind pwr_supervisor pwr_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .discharge_on(discharge_on),
  .out_hiz(out_hiz), .sw_en(sw_en), .ramp_start(ramp_start), .pgood(pgood),
  .fpwm_ok(fpwm_ok), .tset_pulse(tset_pulse), .ov_s(ov_s),
  .thermal_off(thermal_off), .hi_s(hi_s), .lo_s(lo_s), .pg_seen(pg_seen),
  .pg_expire(pg_expire)
);

// File: tb/test_pwr_supervisor.sv
`timescale 1ns/1ps
module test_pwr_supervisor;

  localparam int SDLY = 40;
  localparam int FDLY = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 0, uvlo_cmp = 0, vin_ov_cmp = 0, hot_cmp = 0, cool_cmp = 0;
  logic vout_hi_cmp = 0, vout_lo_cmp = 0, ctl_enable = 0, ctl_fpwm = 0;
  logic [1:0] dev_state;
  logic discharge_on, out_hiz, sw_en, ramp_start, pgood, fpwm_ok, tset_pulse;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pwr_supervisor i_pwr_supervisor (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .uvlo_cmp(uvlo_cmp),
    .vin_ov_cmp(vin_ov_cmp), .hot_cmp(hot_cmp), .cool_cmp(cool_cmp),
    .vout_hi_cmp(vout_hi_cmp), .vout_lo_cmp(vout_lo_cmp),
    .ctl_enable(ctl_enable), .ctl_fpwm(ctl_fpwm), .dev_state(dev_state),
    .discharge_on(discharge_on), .out_hiz(out_hiz), .sw_en(sw_en),
    .ramp_start(ramp_start), .pgood(pgood), .fpwm_ok(fpwm_ok),
    .tset_pulse(tset_pulse)
  );

  // Behavioural reference: input history queue and integer bookkeeping.
  // Bit order of a history word: en, uv, ov, hot, cool, hi, lo (MSB first).
  logic [6:0] hq[$];
  int m_state = 0;
  int m_delay = 0;
  bit m_ready = 0;
  bit m_hot = 0;
  bit m_pulse = 0;
  bit m_pg = 0;
  int m_lowrun = 0;
  bit m_seen = 0;

  initial begin
    hq.push_back(7'd0);
    hq.push_back(7'd0);
  end

  always @(posedge clk) begin
    logic [6:0] s;
    int was;
    if (!rst_n) begin
      hq = {7'd0, 7'd0};
      m_state = 0; m_delay = 0; m_ready = 0; m_hot = 0; m_pulse = 0;
      m_pg = 0; m_lowrun = 0; m_seen = 0;
    end else begin
      s = hq[1];
      was = m_state;
      if (s[6] == 1'b0 || s[5] == 1'b1) m_state = 0;
      else m_state = ctl_enable ? 2 : 1;
      m_pulse = s[3] && !m_hot;
      if (s[3]) m_hot = 1;
      else if (s[2]) m_hot = 0;
      if (was != 2) begin
        m_delay = 0; m_ready = 0;
      end else if (!m_ready) begin
        m_delay++;
        if (m_delay >= SDLY) m_ready = 1;
      end
      if (was != 2) m_seen = 0;
      else if (m_pg) m_seen = 1;
      if (was != 2) begin
        m_pg = 0; m_lowrun = 0;
      end else if (!m_pg) begin
        m_lowrun = 0;
        if (s[1]) m_pg = 1;
      end else if (s[0]) begin
        m_lowrun++;
        if (m_lowrun >= FDLY) begin m_pg = 0; m_lowrun = 0; end
      end else m_lowrun = 0;
      hq.push_front({en_pin, uvlo_cmp, vin_ov_cmp, hot_cmp, cool_cmp,
                     vout_hi_cmp, vout_lo_cmp});
      void'(hq.pop_back());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 R2 R3 dev_state", dev_state, m_state);
      check("R1 discharge_on", discharge_on, m_state == 0);
      check("R2 out_hiz", out_hiz, m_state == 1);
      check("R5 ramp_start", ramp_start, m_ready);
      check("R6 R7 sw_en", sw_en, (m_state == 2) && m_ready && !hq[1][4] && !m_hot);
      check("R8 R9 pgood", pgood, m_pg);
      check("R10 fpwm_ok", fpwm_ok, ctl_fpwm && m_seen);
      check("R7 tset_pulse", tset_pulse, m_pulse);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic sample_check(input string tag, input int act, input int exp);
    @(negedge clk);
    check(tag, act, exp);
  endtask

  initial begin
    step(3);
    // Reset state: off with discharge.
    check("R1 reset dev_state", dev_state, 0);
    check("R1 reset discharge_on", discharge_on, 1);
    check("R9 reset pgood", pgood, 0);
    rst_n = 1'b1;

    // R1: pin low overrides the enable bit.
    ctl_enable = 1; step(6);
    @(negedge clk); check("R1 pin low off", dev_state, 0);

    // R2: interface-only.
    step(0); ctl_enable = 0; en_pin = 1; step(6);
    @(negedge clk); check("R2 iface state", dev_state, 1);
    check("R2 iface hiz", out_hiz, 1);

    // R3 and R5: running, then start delay.
    step(0); ctl_enable = 1; step(2);
    @(negedge clk); check("R3 run state", dev_state, 2);
    check("R5 no early ramp", ramp_start, 0);
    step(SDLY + 2);
    @(negedge clk); check("R5 ramp after delay", sw_en, 1);

    // R4: pin latency of three edges.
    step(0); en_pin = 0; step(2);
    @(negedge clk); check("R4 still running after two edges", dev_state, 2);
    step(0); step(1);
    @(negedge clk); check("R4 off after three edges", dev_state, 0);
    step(0); en_pin = 1; step(SDLY + 6);

    // R1: undervoltage.
    uvlo_cmp = 1; step(4);
    @(negedge clk); check("R1 undervoltage off", dev_state, 0);
    step(0); uvlo_cmp = 0; step(SDLY + 6);

    // R8 / R10: power good, forced-PWM permission.
    ctl_fpwm = 1; step(3);
    @(negedge clk); check("R10 fpwm before pg", fpwm_ok, 0);
    step(0); vout_hi_cmp = 1; step(4);
    @(negedge clk); check("R8 pg rise", pgood, 1);
    check("R10 fpwm after pg", fpwm_ok, 1);
    // Interrupted low run, then a full run.
    step(0); vout_hi_cmp = 0; vout_lo_cmp = 1; step(FDLY - 4);
    vout_lo_cmp = 0; step(2);
    vout_lo_cmp = 1; step(FDLY - 2);
    @(negedge clk); check("R8 pg held after restart", pgood, 1);
    step(0); step(FDLY);
    @(negedge clk); check("R8 pg fell", pgood, 0);
    check("R10 fpwm stays after pg loss", fpwm_ok, 1);

    // R6: overvoltage pause and self-restart.
    step(0); vout_lo_cmp = 0; vin_ov_cmp = 1; step(4);
    @(negedge clk); check("R6 ov stops", sw_en, 0);
    step(0); vin_ov_cmp = 0; step(4);
    @(negedge clk); check("R6 ov restart", sw_en, 1);

    // R7: thermal fault overlapping overvoltage.
    step(0); vin_ov_cmp = 1; step(3); hot_cmp = 1; step(5);
    vin_ov_cmp = 0; hot_cmp = 0; step(8);
    @(negedge clk); check("R7 latched until cool", sw_en, 0);
    step(0); cool_cmp = 1; step(4);
    @(negedge clk); check("R7 restart after cool", sw_en, 1);
    step(0); cool_cmp = 0;

    // Coincidence: pg filter expiry on the edge the running state is left.
    vout_hi_cmp = 1; step(4); vout_hi_cmp = 0; vout_lo_cmp = 1;
    step(FDLY);
    ctl_enable = 0; step(3);
    @(negedge clk); check("R9 pg low after leaving run", pgood, 0);
    check("R10 fpwm cleared after leaving run", fpwm_ok, 0);
    step(0); vout_lo_cmp = 0; ctl_enable = 1; step(SDLY + 4);

    // Randomised mix.
    for (int k = 0; k < 4000; k++) begin
      en_pin      = ($urandom_range(99) < 97);
      uvlo_cmp    = ($urandom_range(99) < 2);
      vin_ov_cmp  = ($urandom_range(99) < 8);
      hot_cmp     = ($urandom_range(99) < 3);
      cool_cmp    = ($urandom_range(99) < 30);
      vout_hi_cmp = ($urandom_range(99) < 20);
      vout_lo_cmp = ($urandom_range(99) < 70);
      ctl_enable  = ($urandom_range(99) < 98);
      ctl_fpwm    = ($urandom_range(99) < 60);
      step(1 + $urandom_range(3));
    end

    step(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule